// File: doc/BRIEF.md
# Universal Shift Register with Shared I/O

This block is a word-wide storage register, eight bits by default, that can hold its contents, shift toward the high end, shift toward the low end, or take a new word in parallel. All state changes happen on the rising clock edge, except the asynchronous active-low reset. A two-bit mode input selects the operation.

Parallel data uses one bidirectional bus in both directions. The block drives that bus with tri-state buffers when both active-low enables are low. It releases the bus when either enable is high, and it also releases the bus by itself while load mode is selected, so an outside agent can place the word to be captured. The lowest and highest bits each have their own serial output. These outputs are always driven, so that several registers can be chained into a longer shifter: the high-end output of one stage feeds the upward serial input of the next, and the low-end output of the next stage feeds the downward serial input of the previous one.

Top module: `univ_shift_reg`

## Requirements
- R1: While rst_ni is low, all register bits are 0 at once, regardless of clock, mode and serial inputs; this is seen on both serial outputs and on the bus.
- R2: With mode_i = 2'b00 the register keeps its value across clock edges.
- R3: With mode_i = 2'b01, on a rising edge ser_up_i enters bit 0 and each bit n moves to bit n+1.
- R4: With mode_i = 2'b10, on a rising edge ser_dn_i enters the top bit and each bit n moves to bit n-1.
- R5: With mode_i = 2'b11, the register captures the value present on data_io at the rising edge.
- R6: When oe_a_ni and oe_b_ni are both low and mode_i is not 2'b11, data_io carries the register contents, bit n on data_io[n].
- R7: bus_en_o is low and the block leaves data_io undriven while oe_a_ni or oe_b_ni is high.
- R8: bus_en_o is low and the block leaves data_io undriven while mode_i = 2'b11, even with both enables low.
- R9: Shifting, holding, loading and reset work normally while the bus drivers are off.
- R10: lsb_o always equals bit 0 and msb_o always equals the top bit, whatever the enables.
- R11: Two instances chained through the serial pins behave as one 16-bit shifter in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| oe_a_ni | input | 1 | Bus output enable, active low |
| oe_b_ni | input | 1 | Bus output enable, active low |
| ser_up_i | input | 1 | Serial bit entering bit 0 in shift-up mode |
| ser_dn_i | input | 1 | Serial bit entering the top bit in shift-down mode |
| data_io | inout | W (8) | Shared parallel bus: register out, load data in |
| bus_en_o | output | 1 | High while the block drives data_io |
| lsb_o | output | 1 | Bit 0 of the register, always driven |
| msb_o | output | 1 | Top bit of the register, always driven |

## Verification
The assertions check on every clock edge that the next register value follows the selected mode: held, shifted up or down with the proper serial bit, or taken from the bus. They also check that the bus enable drops whenever an enable is high or load mode is selected, and that an enabled bus matches the register. Some behaviour only the bench scenarios can show. These are the asynchronous clear between clock edges, operation while the bus is released, and the 16-bit chain of two instances, which the bench compares against a reference model in both shift directions.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_i,
  input  mode_e        mode_i,
  input  logic         ser_up_i,
  input  logic         ser_dn_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    unique case (mode_i)
      MODE_UP:   nxt_o = {cur_i[W-2:0], ser_up_i};
      MODE_DN:   nxt_o = {ser_dn_i, cur_i[W-1:1]};
      MODE_LOAD: nxt_o = load_i;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/usr_bus_drv.sv
module usr_bus_drv
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  input  mode_e        mode_i,
  input  logic [W-1:0] q_i,
  output logic         en_o,
  inout  wire  [W-1:0] bus_io
);
  // load mode frees the bus for incoming data
  assign en_o = ~(oe_a_ni | oe_b_ni | (mode_i == MODE_LOAD));

  for (genvar b = 0; b < W; b++) begin : g_drv
    assign bus_io[b] = en_o ? q_i[b] : 1'bz;
  end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  input  logic         ser_up_i,
  input  logic         ser_dn_i,
  inout  wire  [W-1:0] data_io,
  output logic         bus_en_o,
  output logic         lsb_o,
  output logic         msb_o
);
  localparam int MSB = W - 1;

  mode_e        mode;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  assign mode = mode_e'(mode_i);

  usr_next_state #(.W(W)) u_next (
    .cur_i    (q_r),
    .mode_i   (mode),
    .ser_up_i (ser_up_i),
    .ser_dn_i (ser_dn_i),
    .load_i   (data_io),
    .nxt_o    (q_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= q_nxt;
  end

  usr_bus_drv #(.W(W)) u_bus (
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .mode_i  (mode),
    .q_i     (q_r),
    .en_o    (bus_en_o),
    .bus_io  (data_io)
  );

  assign lsb_o = q_r[0];
  assign msb_o = q_r[MSB];
endmodule

// File: rtl/usr_sva.sv
module usr_sva #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   mode_i,
  input logic         oe_a_ni,
  input logic         oe_b_ni,
  input logic         ser_up_i,
  input logic         ser_dn_i,
  input logic [W-1:0] data_io,
  input logic         bus_en_o,
  input logic [W-1:0] q_i
);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> q_i == $past(q_i));

  assert_shift_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_i == {$past(q_i[W-2:0]), $past(ser_up_i)});

  assert_shift_dn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> q_i == {$past(ser_dn_i), $past(q_i[W-1:1])});

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> q_i == $past(data_io));

  assert_bus_mirror_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> data_io == q_i);

  assert_oe_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_ni || oe_b_ni) |-> !bus_en_o);

  assert_load_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> !bus_en_o);

  // R1: register cleared while reset is held
  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (q_i == '0);
  end
endmodule

bind univ_shift_reg usr_sva #(.W(W)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .oe_a_ni  (oe_a_ni),
  .oe_b_ni  (oe_b_ni),
  .ser_up_i (ser_up_i),
  .ser_dn_i (ser_dn_i),
  .data_io  (data_io),
  .bus_en_o (bus_en_o),
  .q_i      (q_r)
);

// File: tb/univ_shift_reg_bench.sv
`timescale 1ns/1ps
module univ_shift_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic sin_up = 1'b0, sin_dn = 1'b0;

  logic [W-1:0] drv_lo = '0, drv_hi = '0;
  logic drv_en = 1'b0;
  wire  [W-1:0] bus_lo, bus_hi;
  assign bus_lo = drv_en ? drv_lo : {W{1'bz}};
  assign bus_hi = drv_en ? drv_hi : {W{1'bz}};

  logic en_lo, en_hi, lsb_lo, msb_lo, lsb_hi, msb_hi;

  int n_run = 0, n_fail = 0;
  logic [2*W-1:0] ref16 = '0;

  always #4 clk = ~clk;

  // low half of the 16-bit chain
  univ_shift_reg #(.W(W)) u_univ_shift_reg (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n),
    .ser_up_i(sin_up), .ser_dn_i(lsb_hi), .data_io(bus_lo),
    .bus_en_o(en_lo), .lsb_o(lsb_lo), .msb_o(msb_lo)
  );

  // high half
  univ_shift_reg #(.W(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n),
    .ser_up_i(msb_lo), .ser_dn_i(sin_dn), .data_io(bus_hi),
    .bus_en_o(en_hi), .lsb_o(lsb_hi), .msb_o(msb_hi)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // both enables low and mode hold: read both halves from the bus
  task automatic chk_bus(input string req);
    chk({bus_hi, bus_lo} === ref16, req, {bus_hi, bus_lo}, ref16);
  endtask

  task automatic chk_serial(input string req);
    chk({msb_hi, lsb_hi, msb_lo, lsb_lo} === {ref16[15], ref16[8], ref16[7], ref16[0]},
        req, {12'h0, msb_hi, lsb_hi, msb_lo, lsb_lo},
        {12'h0, ref16[15], ref16[8], ref16[7], ref16[0]});
  endtask

  task automatic t_reset();
    @(negedge clk);
    ref16 = '0;
    chk({msb_hi, lsb_hi, msb_lo, lsb_lo} === 4'b0000, "R1", {12'h0, msb_hi, lsb_hi, msb_lo, lsb_lo}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bus("R1");
    chk({en_hi, en_lo} === 2'b11, "R6", {14'h0, en_hi, en_lo}, 16'h3);
  endtask

  task automatic t_load(input logic [15:0] val);
    mode = 2'b11;
    #1;
    chk({en_hi, en_lo} === 2'b00, "R8", {14'h0, en_hi, en_lo}, 16'h0);
    drv_lo = val[7:0];
    drv_hi = val[15:8];
    drv_en = 1'b1;
    step();
    drv_en = 1'b0;
    mode = 2'b00;
    ref16 = val;
    #1;
    chk_bus("R5");
    chk_serial("R10");
  endtask

  task automatic t_hold(input int n);
    mode = 2'b00;
    sin_up = 1'b1;
    sin_dn = 1'b1;
    for (int i = 0; i < n; i++) step();
    chk_bus("R2");
  endtask

  task automatic t_shift_up(input logic [31:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      mode = 2'b01;
      sin_up = pat[i];
      step();
      ref16 = {ref16[14:0], pat[i]};
      chk_bus("R3 R11");
      chk_serial("R10");
    end
    mode = 2'b00;
  endtask

  task automatic t_shift_dn(input logic [31:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      mode = 2'b10;
      sin_dn = pat[i];
      step();
      ref16 = {pat[i], ref16[15:1]};
      chk_bus("R4 R11");
      chk_serial("R10");
    end
    mode = 2'b00;
  endtask

  task automatic t_bus_off();
    oe_a_n = 1'b1;
    #1;
    chk({en_hi, en_lo} === 2'b00, "R7", {14'h0, en_hi, en_lo}, 16'h0);
    mode = 2'b01;
    sin_up = 1'b1;
    step();
    ref16 = {ref16[14:0], 1'b1};
    chk_serial("R10");
    oe_a_n = 1'b0;
    oe_b_n = 1'b1;
    mode = 2'b10;
    sin_dn = 1'b0;
    #1;
    chk({en_hi, en_lo} === 2'b00, "R7", {14'h0, en_hi, en_lo}, 16'h0);
    step();
    ref16 = {1'b0, ref16[15:1]};
    mode = 2'b00;
    oe_b_n = 1'b0;
    #1;
    chk_bus("R9");
    // load while enables are high
    oe_a_n = 1'b1;
    mode = 2'b11;
    drv_lo = 8'h3c;
    drv_hi = 8'hc3;
    drv_en = 1'b1;
    step();
    drv_en = 1'b0;
    mode = 2'b00;
    ref16 = 16'hc33c;
    oe_a_n = 1'b0;
    #1;
    chk_bus("R9");
  endtask

  task automatic t_async_reset();
    #1;
    rst_n = 1'b0;
    #1;
    ref16 = '0;
    chk({msb_hi, lsb_hi, msb_lo, lsb_lo} === 4'b0000, "R1",
        {12'h0, msb_hi, lsb_hi, msb_lo, lsb_lo}, 16'h0);
    chk_bus("R1");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_bus("R1");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_load(16'ha5c3);
    t_hold(3);
    t_shift_up(32'h0000_b2d1, 20);
    t_load(16'h8001);
    t_shift_dn(32'h0001_6e35, 20);
    t_hold(2);
    t_bus_off();
    t_async_reset();
    t_load(16'hffff);
    t_shift_up(32'h0, 4);
    t_shift_dn(32'hf, 4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule